// File: doc/BRIEF.md
# Byte-Wide Stack and Fetch Sequencer

This block owns a 16-bit stack pointer and a 16-bit program counter. It performs byte and word pushes, pops and instruction-stream fetches over a memory port that moves one byte per cycle. A caller presents an operation code together with write data. The sequencer then drives one byte access per cycle. When the last access completes it updates the pointer it used and pulses a completion strobe, with any read value assembled on the response bus.

Words are kept in memory with the most significant byte at the lower address. The stack pointer always names the next free byte, so a push stores at the pointer and then moves it down, and a pop reads just above the pointer and then moves it up. The memory answers each access in the same cycle it is issued. It may flag an error instead. An error aborts the operation without touching either pointer and latches a fault flag together with the failing address. Both pointers can also be written directly through dedicated load inputs.

Top module: `stack_fetch_seq`

## Requirements
- R1: Operation code 0 (byte push) writes `cmdWdata[7:0]` at address SP in one access, then SP becomes SP-1.
- R2: Operation code 1 (word push) writes `cmdWdata[15:8]` at SP-1 in the first access and `cmdWdata[7:0]` at SP in the second access, then SP becomes SP-2.
- R3: Operation code 2 (byte pop) reads the byte at SP+1 and returns it on `rspData[7:0]` with `rspData[15:8]` zero, then SP becomes SP+1.
- R4: Operation code 3 (word pop) reads SP+1 into `rspData[15:8]` in the first access and SP+2 into `rspData[7:0]` in the second access, then SP becomes SP+2.
- R5: Operation code 4 (byte fetch) reads at PC and advances PC by 1. Operation code 5 (word fetch) reads PC as the high byte and PC+1 as the low byte, then advances PC by 2. Fetches leave SP unchanged, and stack operations leave PC unchanged.
- R6: All address arithmetic and pointer updates wrap modulo 2^16.
- R7: A command is taken only while `cmdReady` is high. The first access is issued in the cycle after acceptance, and each access occupies one cycle. `rspDone` is high for exactly one cycle, the cycle after the last access, and the pointer update is visible in that same cycle. `memWe` and `memRe` are never high together.
- R8: If `memErr` is high during an access, the operation ends without `rspDone`. `fault` rises in the next cycle, with `faultAddr` equal to the failing address. SP and PC keep their values from before the command, and `cmdReady` returns high. `fault` stays high until the next command is accepted, which clears it.
- R9: `spLoad` and `pcLoad` take effect only while `cmdReady` is high. A load in the same cycle as an accepted command is applied before that command's first access. Loads while busy are ignored.
- R10: Operation codes 6 and 7 are never accepted. They cause no memory access, no `rspDone` and no change to SP, PC or `fault`.
- R11: After reset, SP and PC are zero, `fault` is low, `cmdReady` is high, and `rspDone`, `memWe` and `memRe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 3 | Operation code (0..5 legal) |
| cmdWdata | input | 16 | Push data |
| cmdReady | output | 1 | Idle, able to take a command or load |
| spLoad | input | 1 | Direct stack pointer write |
| spLoadVal | input | 16 | Value for stack pointer write |
| pcLoad | input | 1 | Direct program counter write |
| pcLoadVal | input | 16 | Value for program counter write |
| memAddr | output | 16 | Byte address of current access (zero when idle) |
| memWe | output | 1 | Write access this cycle |
| memRe | output | 1 | Read access this cycle |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte returned in the same cycle |
| memErr | input | 1 | Access failed in this cycle |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Assembled read value |
| fault | output | 1 | Sticky abort flag |
| faultAddr | output | 16 | Address of the failing access |
| sp | output | 16 | Current stack pointer |
| pc | output | 16 | Current program counter |

## Verification
The embedded properties check several rules on every cycle. The completion strobe is a single-cycle pulse, no completion follows an abort, and read and write strobes are exclusive. The stack pointer holds still through every non-final or aborted access. A rising fault carries the address that was on the bus one cycle earlier, the fault stays set until a command is taken, and the pointer steps for byte pushes, word pops and word fetches are correct. The bench scenarios are the only place where the following can be shown: that the right byte lands at the right big-endian address, that read values are assembled correctly, that pointers wrap across 0xFFFF/0x0000, and that load ordering follows R9 when a load coincides with a command or arrives while busy. They also cover aborts on either access of a word operation.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [2:0] {
    OP_PUSH8   = 3'd0,
    OP_PUSH16  = 3'd1,
    OP_POP8    = 3'd2,
    OP_POP16   = 3'd3,
    OP_FETCH8  = 3'd4,
    OP_FETCH16 = 3'd5
  } seqOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;  // command taken this cycle
    logic       active;  // a byte access is on the bus
    logic       beat;    // 0: first access, 1: second access
    logic       commit;  // final access finishing without error
    logic       abort;   // access failing this cycle
    logic [2:0] op;      // latched operation
  } seqStrb_t;

endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       memErr,
  output logic       cmdReady,
  output logic       rspDone,
  output seqStrb_t   strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT0, ST_BEAT1, ST_DONE} seqSt_e;

  seqSt_e     stQ, stNx;
  logic [2:0] opQ;
  logic       opLegal;
  logic       isWord;
  logic       accept;
  logic       active;
  logic       lastBeat;

  // word operations have odd codes
  assign opLegal  = (cmdOp <= 3'd5);
  assign isWord   = opQ[0];
  assign accept   = (stQ == ST_IDLE) && cmdValid && opLegal;
  assign active   = (stQ == ST_BEAT0) || (stQ == ST_BEAT1);
  assign lastBeat = (stQ == ST_BEAT1) || ((stQ == ST_BEAT0) && !isWord);

  always_comb begin
    stNx = stQ;
    unique case (stQ)
      ST_IDLE:  if (accept) stNx = ST_BEAT0;
      ST_BEAT0: begin
        if (memErr)      stNx = ST_IDLE;
        else if (isWord) stNx = ST_BEAT1;
        else             stNx = ST_DONE;
      end
      ST_BEAT1: stNx = memErr ? ST_IDLE : ST_DONE;
      ST_DONE:  stNx = ST_IDLE;
      default:  stNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ <= ST_IDLE;
      opQ <= 3'd0;
    end else begin
      stQ <= stNx;
      if (accept) opQ <= cmdOp;
    end
  end

  assign cmdReady    = (stQ == ST_IDLE);
  assign rspDone     = (stQ == ST_DONE);
  assign strb.accept = accept;
  assign strb.active = active;
  assign strb.beat   = (stQ == ST_BEAT1);
  assign strb.commit = active && lastBeat && !memErr;
  assign strb.abort  = active && memErr;
  assign strb.op     = opQ;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rspDone |=> !rspDone);

  // R8: an aborted access never leads to completion
  p_abort_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.abort |=> (!rspDone && cmdReady));

  // R10: illegal codes leave the sequencer idle
  p_illegal_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReady && cmdValid && !opLegal) |=> cmdReady);

endmodule

// File: rtl/sfs_dpath.sv
module sfs_dpath
  import sfs_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seqStrb_t        strb,
  input  logic            idle,
  input  logic [2*BW-1:0] cmdWdata,
  input  logic            spLoad,
  input  logic [AW-1:0]   spLoadVal,
  input  logic            pcLoad,
  input  logic [AW-1:0]   pcLoadVal,
  input  logic [BW-1:0]   memRdata,
  input  logic            memErr,
  output logic [AW-1:0]   memAddr,
  output logic            memWe,
  output logic            memRe,
  output logic [BW-1:0]   memWdata,
  output logic [2*BW-1:0] rspData,
  output logic            fault,
  output logic [AW-1:0]   faultAddr,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   pc
);

  localparam int          WW    = 2 * BW;
  localparam int          LANES = WW / BW;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] spQ, pcQ, spNx, pcNx;
  logic [AW-1:0] accAddr;
  logic [WW-1:0] wdQ;
  logic [BW-1:0] laneQ [LANES];
  logic          isPush, isFetch, isWord, laneHi, rdStrobe;
  logic          faultQ;
  logic [AW-1:0] faultAddrQ;

  assign isPush  = (strb.op[2:1] == 2'b00);
  assign isFetch = strb.op[2];
  assign isWord  = strb.op[0];

  // address of the current byte access
  always_comb begin
    unique case (strb.op)
      OP_PUSH8:   accAddr = spQ;
      OP_PUSH16:  accAddr = strb.beat ? spQ : spQ - ONE;
      OP_POP8:    accAddr = spQ + ONE;
      OP_POP16:   accAddr = strb.beat ? spQ + TWO : spQ + ONE;
      OP_FETCH8:  accAddr = pcQ;
      OP_FETCH16: accAddr = strb.beat ? pcQ + ONE : pcQ;
      default:    accAddr = spQ;
    endcase
  end

  // pointer values after a committed operation
  always_comb begin
    spNx = spQ;
    pcNx = pcQ;
    unique case (strb.op)
      OP_PUSH8:   spNx = spQ - ONE;
      OP_PUSH16:  spNx = spQ - TWO;
      OP_POP8:    spNx = spQ + ONE;
      OP_POP16:   spNx = spQ + TWO;
      OP_FETCH8:  pcNx = pcQ + ONE;
      OP_FETCH16: pcNx = pcQ + TWO;
      default: ;
    endcase
  end

  assign memAddr  = strb.active ? accAddr : '0;
  assign memWe    = strb.active && isPush;
  assign memRe    = strb.active && !isPush;
  assign memWdata = !memWe ? '0 :
                    (isWord && !strb.beat) ? wdQ[WW-1:BW] : wdQ[BW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spQ <= '0;
      pcQ <= '0;
      wdQ <= '0;
    end else begin
      if (strb.accept) wdQ <= cmdWdata;
      if (idle && spLoad)                   spQ <= spLoadVal;
      else if (strb.commit && !isFetch)     spQ <= spNx;
      if (idle && pcLoad)                   pcQ <= pcLoadVal;
      else if (strb.commit && isFetch)      pcQ <= pcNx;
    end
  end

  // read assembly: first access of a word fills the upper lane
  assign laneHi   = isWord && !strb.beat;
  assign rdStrobe = memRe && !memErr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 laneQ[g] <= '0;
      else if (strb.accept)                       laneQ[g] <= '0;
      else if (rdStrobe && ((g == 1) == laneHi))  laneQ[g] <= memRdata;
    end
  end

  assign rspData = {laneQ[1], laneQ[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faultQ     <= 1'b0;
      faultAddrQ <= '0;
    end else if (strb.accept) begin
      faultQ     <= 1'b0;
    end else if (strb.abort) begin
      faultQ     <= 1'b1;
      faultAddrQ <= accAddr;
    end
  end

  assign fault     = faultQ;
  assign faultAddr = faultAddrQ;
  assign sp        = spQ;
  assign pc        = pcQ;

  // R7: one kind of access per cycle
  p_excl_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(memWe && memRe));

  // R9: stack pointer frozen while busy unless the final access commits
  p_sp_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.active && !strb.commit) |=> $stable(spQ));

  // R8: reported address is the one on the bus when the error came
  p_fault_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultQ) |-> (faultAddr == $past(memAddr)));

  // R8: fault is sticky until a command is taken
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (faultQ && !strb.accept) |=> faultQ);

  // R1: byte push moves the pointer down by one
  p_push8_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && strb.op == OP_PUSH8) |=> (spQ == $past(spQ) - ONE));

  // R4: word pop moves the pointer up by two
  p_pop16_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && strb.op == OP_POP16) |=> (spQ == $past(spQ) + TWO));

  // R5: word fetch advances by two and leaves the stack alone
  p_fetch16_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commit && strb.op == OP_FETCH16) |=>
      (pcQ == $past(pcQ) + TWO && $stable(spQ)));

endmodule

// File: rtl/stack_fetch_seq.sv
module stack_fetch_seq
  import sfs_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic [2:0]      cmdOp,
  input  logic [2*BW-1:0] cmdWdata,
  output logic            cmdReady,
  input  logic            spLoad,
  input  logic [AW-1:0]   spLoadVal,
  input  logic            pcLoad,
  input  logic [AW-1:0]   pcLoadVal,
  output logic [AW-1:0]   memAddr,
  output logic            memWe,
  output logic            memRe,
  output logic [BW-1:0]   memWdata,
  input  logic [BW-1:0]   memRdata,
  input  logic            memErr,
  output logic            rspDone,
  output logic [2*BW-1:0] rspData,
  output logic            fault,
  output logic [AW-1:0]   faultAddr,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   pc
);

  seqStrb_t strb;

  sfs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .memErr   (memErr),
    .cmdReady (cmdReady),
    .rspDone  (rspDone),
    .strb     (strb)
  );

  sfs_dpath #(.AW(AW), .BW(BW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .idle      (cmdReady),
    .cmdWdata  (cmdWdata),
    .spLoad    (spLoad),
    .spLoadVal (spLoadVal),
    .pcLoad    (pcLoad),
    .pcLoadVal (pcLoadVal),
    .memRdata  (memRdata),
    .memErr    (memErr),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memRe     (memRe),
    .memWdata  (memWdata),
    .rspData   (rspData),
    .fault     (fault),
    .faultAddr (faultAddr),
    .sp        (sp),
    .pc        (pc)
  );

endmodule

// File: tb/stack_fetch_seq_tb.sv
module stack_fetch_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [15:0] cmdWdata = 16'd0;
  logic        cmdReady;
  logic        spLoad = 1'b0;
  logic [15:0] spLoadVal = 16'd0;
  logic        pcLoad = 1'b0;
  logic [15:0] pcLoadVal = 16'd0;
  logic [15:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = 8'd0;
  logic        memErr = 1'b0;
  logic        rspDone;
  logic [15:0] rspData;
  logic        fault;
  logic [15:0] faultAddr;
  logic [15:0] sp, pc;

  int total = 0;
  int bad   = 0;

  logic [15:0] refSp = 16'd0;
  logic [15:0] refPc = 16'd0;
  logic        errOn = 1'b0;
  logic [15:0] errAddr = 16'd0;
  logic [7:0]  memModel [int];

  always #10 clk = ~clk;

  stack_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdWdata(cmdWdata), .cmdReady(cmdReady), .spLoad(spLoad),
    .spLoadVal(spLoadVal), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .memErr(memErr), .rspDone(rspDone),
    .rspData(rspData), .fault(fault), .faultAddr(faultAddr), .sp(sp), .pc(pc)
  );

  function automatic logic [7:0] rdModel(logic [15:0] a);
    if (memModel.exists(int'(a))) return memModel[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory answers within the cycle; sampled away from the rising edge
  always @(negedge clk) begin
    memErr   = errOn && (memWe || memRe) && (memAddr == errAddr);
    memRdata = memRe ? rdModel(memAddr) : 8'h00;
    if (memWe && !memErr) memModel[int'(memAddr)] = memWdata;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected address for each access, from R1..R5
  function automatic logic [15:0] expAddr(logic [2:0] op, bit beat,
                                         logic [15:0] s, logic [15:0] p);
    case (op)
      3'd0: return s;
      3'd1: return beat ? s : s - 16'd1;
      3'd2: return s + 16'd1;
      3'd3: return beat ? s + 16'd2 : s + 16'd1;
      3'd4: return p;
      default: return beat ? p + 16'd1 : p;
    endcase
  endfunction

  function automatic logic [15:0] expSp(logic [2:0] op, logic [15:0] s);
    case (op)
      3'd0: return s - 16'd1;
      3'd1: return s - 16'd2;
      3'd2: return s + 16'd1;
      3'd3: return s + 16'd2;
      default: return s;
    endcase
  endfunction

  function automatic logic [15:0] expPc(logic [2:0] op, logic [15:0] p);
    if (op == 3'd4) return p + 16'd1;
    if (op == 3'd5) return p + 16'd2;
    return p;
  endfunction

  task automatic loadPtrs(logic [15:0] s, logic [15:0] p);
    @(negedge clk);
    spLoad = 1'b1; spLoadVal = s; pcLoad = 1'b1; pcLoadVal = p;
    @(negedge clk);
    spLoad = 1'b0; pcLoad = 1'b0;
    refSp = s; refPc = p;
    check("R9 sp load", 32'(sp), 32'(s));
    check("R9 pc load", 32'(pc), 32'(p));
  endtask

  // withLoad: load both pointers in the accept cycle; busyLoad: try loads mid-command
  task automatic runCmd(logic [2:0] op, logic [15:0] wd, bit withLoad,
                        logic [15:0] ldVal, bit busyLoad);
    int nb;
    int errBeat;
    logic [15:0] a0, a1, expRd, spB, pcB;
    nb = op[0] ? 2 : 1;
    @(negedge clk);
    if (withLoad) begin
      spLoad = 1'b1; spLoadVal = ldVal; pcLoad = 1'b1; pcLoadVal = ldVal;
      refSp = ldVal; refPc = ldVal;
    end
    cmdValid = 1'b1; cmdOp = op; cmdWdata = wd;
    spB = refSp; pcB = refPc;
    a0 = expAddr(op, 1'b0, spB, pcB);
    a1 = expAddr(op, 1'b1, spB, pcB);
    errBeat = -1;
    if (errOn && a0 == errAddr) errBeat = 0;
    else if (nb == 2 && errOn && a1 == errAddr) errBeat = 1;
    expRd = (nb == 2) ? {rdModel(a0), rdModel(a1)} : {8'h00, rdModel(a0)};
    if (op <= 3'd1) expRd = 16'h0000;
    @(negedge clk);
    cmdValid = 1'b0; spLoad = 1'b0; pcLoad = 1'b0;
    if (busyLoad) begin
      spLoad = 1'b1; spLoadVal = 16'h5A5A; pcLoad = 1'b1; pcLoadVal = 16'hA5A5;
    end
    check("R7 busy not ready", 32'(cmdReady), 32'd0);
    check("R8 fault cleared on accept", 32'(fault), 32'd0);
    check("R1-R5 first address", 32'(memAddr), 32'(a0));
    if (op <= 3'd1)
      check("R2 first byte", 32'(memWdata), (nb == 2) ? 32'(wd[15:8]) : 32'(wd[7:0]));
    if (errBeat == 0) begin
      @(negedge clk);
      spLoad = 1'b0; pcLoad = 1'b0;
      check("R8 fault raised", 32'(fault), 32'd1);
      check("R8 fault address", 32'(faultAddr), 32'(a0));
      check("R8 no done", 32'(rspDone), 32'd0);
      check("R8 sp kept", 32'(sp), 32'(spB));
      check("R8 pc kept", 32'(pc), 32'(pcB));
      check("R8 ready again", 32'(cmdReady), 32'd1);
      return;
    end
    if (nb == 2) begin
      @(negedge clk);
      spLoad = 1'b0; pcLoad = 1'b0;
      check("R7 second address", 32'(memAddr), 32'(a1));
      check("R7 no early done", 32'(rspDone), 32'd0);
      if (op == 3'd1) check("R2 second byte", 32'(memWdata), 32'(wd[7:0]));
      if (errBeat == 1) begin
        @(negedge clk);
        check("R8 fault raised", 32'(fault), 32'd1);
        check("R8 fault address", 32'(faultAddr), 32'(a1));
        check("R8 no done", 32'(rspDone), 32'd0);
        check("R8 sp kept", 32'(sp), 32'(spB));
        check("R8 pc kept", 32'(pc), 32'(pcB));
        return;
      end
    end
    @(negedge clk);
    spLoad = 1'b0; pcLoad = 1'b0;
    refSp = expSp(op, spB);
    refPc = expPc(op, pcB);
    check("R7 done pulse", 32'(rspDone), 32'd1);
    check("R1-R6 sp update", 32'(sp), 32'(refSp));
    check("R5 pc update", 32'(pc), 32'(refPc));
    check("R3 R4 R5 read data", 32'(rspData), 32'(expRd));
    if (op == 3'd0) check("R1 stored byte", 32'(rdModel(a0)), 32'(wd[7:0]));
    if (op == 3'd1) begin
      check("R2 high byte low address", 32'(rdModel(a0)), 32'(wd[15:8]));
      check("R2 low byte high address", 32'(rdModel(a1)), 32'(wd[7:0]));
    end
    @(negedge clk);
    check("R7 done one cycle", 32'(rspDone), 32'd0);
  endtask

  task automatic illegalCmd(logic [2:0] op);
    logic [15:0] s0, p0;
    logic f0;
    s0 = sp; p0 = pc; f0 = fault;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R10 stays ready", 32'(cmdReady), 32'd1);
    check("R10 no access", 32'(memWe | memRe), 32'd0);
    @(negedge clk);
    check("R10 no done", 32'(rspDone), 32'd0);
    check("R10 sp same", 32'(sp), 32'(s0));
    check("R10 pc same", 32'(pc), 32'(p0));
    check("R10 fault same", 32'(fault), 32'(f0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset ready", 32'(cmdReady), 32'd1);
    check("R11 reset sp", 32'(sp), 32'd0);
    check("R11 reset pc", 32'(pc), 32'd0);
    check("R11 reset fault", 32'(fault), 32'd0);
    check("R11 reset strobes", 32'({rspDone, memWe, memRe}), 32'd0);
    rst_n = 1'b1;

    loadPtrs(16'h1000, 16'h2000);
    runCmd(3'd0, 16'h00A5, 1'b0, 16'h0, 1'b0);   // R1
    runCmd(3'd1, 16'hBEEF, 1'b0, 16'h0, 1'b0);   // R2
    runCmd(3'd3, 16'h0000, 1'b0, 16'h0, 1'b0);   // R4 returns BEEF
    check("R4 pop returns pushed word", 32'(rspData), 32'h0000BEEF);
    runCmd(3'd2, 16'h0000, 1'b0, 16'h0, 1'b0);   // R3 returns A5
    check("R3 pop returns pushed byte", 32'(rspData), 32'h000000A5);
    runCmd(3'd4, 16'h0000, 1'b0, 16'h0, 1'b0);   // R5
    runCmd(3'd5, 16'h0000, 1'b0, 16'h0, 1'b0);   // R5

    // R6 wrap cases
    loadPtrs(16'hFFFF, 16'hFFFF);
    runCmd(3'd2, 16'h0000, 1'b0, 16'h0, 1'b0);
    check("R6 pop wraps to zero", 32'(sp), 32'd0);
    runCmd(3'd1, 16'h1234, 1'b0, 16'h0, 1'b0);
    check("R6 push wraps down", 32'(sp), 32'hFFFE);
    runCmd(3'd5, 16'h0000, 1'b0, 16'h0, 1'b0);
    check("R6 fetch wraps", 32'(pc), 32'h0001);

    // R9 load coinciding with a command, and loads while busy
    runCmd(3'd0, 16'h0077, 1'b1, 16'h3000, 1'b0);
    check("R9 same-cycle load used", 32'(sp), 32'h2FFF);
    runCmd(3'd3, 16'h0000, 1'b0, 16'h0, 1'b1);
    check("R9 busy load ignored", 32'(sp), 32'h3001);

    // R8 abort on second access of a word pop, then sticky, then cleared
    errOn = 1'b1; errAddr = refSp + 16'd2;
    runCmd(3'd3, 16'h0000, 1'b0, 16'h0, 1'b0);
    errOn = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 fault sticky", 32'(fault), 32'd1);
    illegalCmd(3'd6);
    illegalCmd(3'd7);
    runCmd(3'd4, 16'h0000, 1'b0, 16'h0, 1'b0);
    check("R8 fault cleared", 32'(fault), 32'd0);
    // R8 abort on first access of a word push
    errOn = 1'b1; errAddr = refSp - 16'd1;
    runCmd(3'd1, 16'hCAFE, 1'b0, 16'h0, 1'b0);
    errOn = 1'b0;

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      bit wl, bl;
      op = 3'($urandom_range(0, 5));
      wl = ($urandom_range(0, 15) == 0);
      bl = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 9) == 0) begin
        errOn = 1'b1;
        errAddr = expAddr(op, 1'($urandom_range(0, 1)), refSp, refPc);
        if (wl) wl = 1'b0;
      end else begin
        errOn = 1'b0;
      end
      runCmd(op, 16'($urandom()), wl, 16'($urandom()), bl);
      errOn = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule